// File: doc/BRIEF.md
# Receive Byte Queue with Threshold-Driven RTS

This block sits between a serial deserializer and a host bus. Each received byte is pushed into a circular store. The host drains the store with read strobes of two sizes. A narrow read removes one byte. A wide read removes four bytes at once, packed into a 32-bit word with the oldest byte in the low lane. The block reports its fill level, a receive-ready indication with a programmable minimum count, and a small set of status flags.

The block also drives the request-to-send line from its own fill level. It uses two programmable thresholds, so the line has hysteresis. The line is asserted (high, meaning "stop sending") once the level reaches the upper threshold. It is released (low, meaning "send again") once the level has drained to the lower threshold. Between the two thresholds it keeps its previous state. This control is active only when three conditions hold together: the control bit in the configuration word is set, the queue is enabled, and the handshake mode is selected.

Configuration word fields:

| Field | Bits |
|---|---|
| Ready count select | 5:4 |
| RTS control enable | 7 |
| Upper threshold | 21:16 |
| Lower threshold | 29:24 |

Top module: `rxq_rts_fifo`

## Requirements
- R1: After reset, and on the clock edge after `clr` is high, `level` is 0, `rts` is low, `ev_empty` is 1, and `ev_overrun` and `ev_ptr_err` are 0. `clr` takes priority over a push or read in the same cycle.
- R2: A push (`push_vld` high while `fifo_en` is high and the queue is not full) stores `push_byte` and raises `level` by one on that clock edge. `ev_full` is 1 exactly when `level` equals DEPTH (default 32). `ev_empty` is 1 exactly when `level` is 0.
- R3: A push while `level` equals DEPTH is discarded. It sets the sticky `ev_overrun` flag and leaves the stored bytes and `level` unchanged.
- R4: A narrow read (`pop_req` high with `pop_wide`=0) removes the oldest byte. It places that byte in `rd_data[7:0]` and zeros in `rd_data[31:8]`, valid from the clock edge that performs the read. `level` drops by one.
- R5: A wide read (`pop_wide`=1) removes the four oldest bytes. The oldest goes to `rd_data[7:0]`, and the next three go to bits 15:8, 23:16 and 31:24 in age order. `level` drops by four.
- R6: A read that asks for more bytes than `level` holds removes nothing. It leaves `rd_data` unchanged and sets the sticky `ev_ptr_err` flag.
- R7: `rx_ready` is high when `level` reaches the count selected by `cfg[5:4]`. The encoding is 0 for one byte, 1 for two bytes, and 2 for four bytes. The value 3 also means four bytes.
- R8: While control is active, `rts` goes high on the clock edge at which `level` becomes greater than or equal to `cfg[21:16]`.
- R9: While control is active, `rts` goes low on the clock edge at which `level` becomes less than or equal to `cfg[29:24]`. Strictly between the two thresholds, `rts` holds its value.
- R10: RTS control is active only when `cfg[7]`, `fifo_en` and `hs_mode` are all 1. On any edge where control is inactive, `rts` becomes low.
- R11: `ev_thr_hi` is 1 when `level >= cfg[21:16]`. `ev_thr_lo` is 1 when `level <= cfg[29:24]`.
- R12: While `fifo_en` is 0, pushes and reads have no effect on the stored bytes, `level` or `rd_data`, and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | Queue enable |
| hs_mode | input | 1 | Hardware handshake mode selected |
| clr | input | 1 | Synchronous clear of contents, flags and RTS |
| cfg | input | 32 | Configuration word (fields listed above) |
| push_vld | input | 1 | Byte push strobe from the deserializer |
| push_byte | input | 8 | Byte to push |
| pop_req | input | 1 | Host read strobe |
| pop_wide | input | 1 | Read size: 0 = one byte, 1 = four bytes |
| rd_data | output | 32 | Data returned by the last accepted read |
| rx_ready | output | 1 | Level has reached the selected ready count |
| level | output | 6 | Number of stored bytes |
| ev_empty | output | 1 | Queue empty |
| ev_full | output | 1 | Queue full |
| ev_thr_hi | output | 1 | Level at or above the upper threshold |
| ev_thr_lo | output | 1 | Level at or below the lower threshold |
| ev_ptr_err | output | 1 | Sticky: oversized read was rejected |
| ev_overrun | output | 1 | Sticky: push was discarded while full |
| rts | output | 1 | Request-to-send line, high means "stop sending" |

## Verification
The threshold properties assume a valid configuration, 0 < lower < upper <= DEPTH, and only judge RTS edges on cycles where the configuration word did not change. The bench satisfies this by changing `cfg` only on falling clock edges between operations and by always using thresholds 2 and 6.

The overrun and pointer-error properties skip cycles in which the opposite operation coincides. The bench issues one operation per step, so every push or read it makes is covered.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LVLW = 6;
  localparam int WORD_LANES = 4;

  typedef enum logic [1:0] {
    RDY_ONE  = 2'd0,
    RDY_TWO  = 2'd1,
    RDY_FOUR = 2'd2,
    RDY_RSVD = 2'd3
  } rdy_mode_e;

  typedef struct packed {
    logic [LVLW-1:0] hi;
    logic [LVLW-1:0] lo;
    logic            rts_ctl;
    rdy_mode_e       rdy;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [31:0] w);
    cfg_t c;
    c.hi      = w[21:16];
    c.lo      = w[29:24];
    c.rts_ctl = w[7];
    c.rdy     = rdy_mode_e'(w[5:4]);
    return c;
  endfunction

  // minimum level that raises the ready indication
  function automatic logic [2:0] rdy_need(input rdy_mode_e m);
    case (m)
      RDY_ONE: return 3'd1;
      RDY_TWO: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // hysteresis: upper threshold wins, hold inside the band
  function automatic logic rts_step(input logic cur, input logic [LVLW-1:0] lvl,
                                    input logic [LVLW-1:0] hi, input logic [LVLW-1:0] lo);
    if (lvl >= hi) return 1'b1;
    else if (lvl <= lo) return 1'b0;
    else return cur;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  input  logic        rd_en,
  input  logic        rd_wide,
  output logic [31:0] rd_data
);
  import rxq_pkg::*;

  logic [7:0]                  mem [DEPTH];
  logic [AW-1:0]               wr_ptr, rd_ptr;
  logic [WORD_LANES-1:0][7:0]  lane;

  for (genvar g = 0; g < WORD_LANES; g++) begin : g_lane
    logic [AW-1:0] addr;
    assign addr = rd_ptr + AW'(g);
    if (g == 0) begin : g_first
      assign lane[g] = mem[addr];
    end else begin : g_rest
      assign lane[g] = rd_wide ? mem[addr] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) begin
        rd_ptr  <= rd_ptr + (rd_wide ? AW'(WORD_LANES) : AW'(1));
        rd_data <= lane;
      end
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push_req,
  input  logic                     pop_req,
  input  logic                     pop_wide,
  output logic [rxq_pkg::LVLW-1:0] level,
  output logic [rxq_pkg::LVLW-1:0] lvl_nxt,
  output logic                     push_ok,
  output logic                     push_drop,
  output logic                     pop_ok,
  output logic                     pop_bad,
  output logic                     ovf,
  output logic                     perr
);
  import rxq_pkg::*;

  localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);

  logic [2:0]      pop_n;
  logic [LVLW-1:0] add_v, sub_v;

  always_comb begin
    pop_n     = pop_wide ? 3'd4 : 3'd1;
    push_ok   = push_req && (level != FULL_LVL);
    push_drop = push_req && (level == FULL_LVL);
    pop_ok    = pop_req && (LVLW'(pop_n) <= level);
    pop_bad   = pop_req && !pop_ok;
    add_v     = {{(LVLW-1){1'b0}}, push_ok};
    sub_v     = pop_ok ? LVLW'(pop_n) : '0;
    lvl_nxt   = clr ? '0 : level + add_v - sub_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      ovf   <= 1'b0;
      perr  <= 1'b0;
    end else begin
      level <= lvl_nxt;
      if (clr) begin
        ovf  <= 1'b0;
        perr <= 1'b0;
      end else begin
        if (push_drop) ovf <= 1'b1;
        if (pop_bad) perr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     active,
  input  logic [rxq_pkg::LVLW-1:0] lvl_nxt,
  input  logic [rxq_pkg::LVLW-1:0] hi,
  input  logic [rxq_pkg::LVLW-1:0] lo,
  output logic                     rts
);
  import rxq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts <= 1'b0;
    else if (clr || !active) rts <= 1'b0;
    else rts <= rts_step(rts, lvl_nxt, hi, lo);
  end
endmodule

// File: rtl/rxq_rts_fifo.sv
module rxq_rts_fifo #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic        hs_mode,
  input  logic        clr,
  input  logic [31:0] cfg,
  input  logic        push_vld,
  input  logic [7:0]  push_byte,
  input  logic        pop_req,
  input  logic        pop_wide,
  output logic [31:0] rd_data,
  output logic        rx_ready,
  output logic [5:0]  level,
  output logic        ev_empty,
  output logic        ev_full,
  output logic        ev_thr_hi,
  output logic        ev_thr_lo,
  output logic        ev_ptr_err,
  output logic        ev_overrun,
  output logic        rts
);
  import rxq_pkg::*;

  localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);

  cfg_t            cfg_d;
  logic            push_req_g, pop_req_g;
  logic            push_ok, push_drop, pop_ok, pop_bad;
  logic            rts_active;
  logic [LVLW-1:0] lvl_nxt;

  assign cfg_d      = decode_cfg(cfg);
  assign push_req_g = push_vld && fifo_en;
  assign pop_req_g  = pop_req && fifo_en;
  assign rts_active = cfg_d.rts_ctl && fifo_en && hs_mode;

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push_req(push_req_g), .pop_req(pop_req_g), .pop_wide(pop_wide),
    .level(level), .lvl_nxt(lvl_nxt),
    .push_ok(push_ok), .push_drop(push_drop), .pop_ok(pop_ok), .pop_bad(pop_bad),
    .ovf(ev_overrun), .perr(ev_ptr_err)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(push_ok && !clr), .wr_byte(push_byte),
    .rd_en(pop_ok && !clr), .rd_wide(pop_wide),
    .rd_data(rd_data)
  );

  rxq_rts u_rts (
    .clk(clk), .rst_n(rst_n), .clr(clr), .active(rts_active),
    .lvl_nxt(lvl_nxt), .hi(cfg_d.hi), .lo(cfg_d.lo), .rts(rts)
  );

  assign ev_empty  = (level == '0);
  assign ev_full   = (level == FULL_LVL);
  assign ev_thr_hi = (level >= cfg_d.hi);
  assign ev_thr_lo = (level <= cfg_d.lo);
  assign rx_ready  = (level >= LVLW'(rdy_need(cfg_d.rdy)));
endmodule

// File: rtl/rxq_rts_fifo_chk.sv
module rxq_rts_fifo_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic [31:0] cfg,
  input logic        push_vld,
  input logic        pop_req,
  input logic [5:0]  level,
  input logic        rts,
  input logic        ev_empty,
  input logic        ev_full,
  input logic        ev_overrun,
  input logic        ev_ptr_err,
  input logic        push_drop,
  input logic        pop_bad,
  input logic        rts_active
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= 6'(DEPTH));

  assert_flag_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_empty, ev_full}));

  assert_drop_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req && !clr) |=> (ev_overrun && level == 6'(DEPTH)));

  assert_bad_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_bad && !push_vld && !clr) |=> (ev_ptr_err && $stable(level)));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == 6'd0 && !rts && !ev_overrun && !ev_ptr_err));

  assert_rts_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts) && $stable(cfg)) |-> (level >= cfg[21:16]));

  assert_rts_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts) && $stable(cfg) && $past(rts_active) && !$past(clr)) |-> (level <= cfg[29:24]));

  assert_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_active |=> !rts);
endmodule

bind rxq_rts_fifo rxq_rts_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cfg(cfg),
  .push_vld(push_vld), .pop_req(pop_req), .level(level), .rts(rts),
  .ev_empty(ev_empty), .ev_full(ev_full), .ev_overrun(ev_overrun),
  .ev_ptr_err(ev_ptr_err), .push_drop(push_drop), .pop_bad(pop_bad),
  .rts_active(rts_active)
);

// File: tb/sim_rxq_rts_fifo.sv
module sim_rxq_rts_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1, hs_mode = 1'b1, clr = 1'b0;
  logic [31:0] cfg = '0;
  logic        push_vld = 1'b0, pop_req = 1'b0, pop_wide = 1'b0;
  logic [7:0]  push_byte = '0;
  logic [31:0] rd_data;
  logic        rx_ready, ev_empty, ev_full, ev_thr_hi, ev_thr_lo, ev_ptr_err, ev_overrun, rts;
  logic [5:0]  level;

  int total = 0, bad = 0;
  bit done = 0;
  byte unsigned mdl[$];
  logic [31:0] exp_rd = '0;

  always #10 clk = ~clk;

  rxq_rts_fifo u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .hs_mode(hs_mode), .clr(clr),
    .cfg(cfg), .push_vld(push_vld), .push_byte(push_byte), .pop_req(pop_req),
    .pop_wide(pop_wide), .rd_data(rd_data), .rx_ready(rx_ready), .level(level),
    .ev_empty(ev_empty), .ev_full(ev_full), .ev_thr_hi(ev_thr_hi),
    .ev_thr_lo(ev_thr_lo), .ev_ptr_err(ev_ptr_err), .ev_overrun(ev_overrun), .rts(rts)
  );

  // entry: {op, expected level, expected rts}; op 0 push, 1 narrow read, 2 wide read
  localparam logic [8:0] VEC [20] = '{
    {2'd0, 6'd1, 1'b0}, {2'd0, 6'd2, 1'b0}, {2'd0, 6'd3, 1'b0}, {2'd0, 6'd4, 1'b0},
    {2'd0, 6'd5, 1'b0}, {2'd0, 6'd6, 1'b1}, {2'd1, 6'd5, 1'b1}, {2'd2, 6'd1, 1'b0},
    {2'd0, 6'd2, 1'b0}, {2'd0, 6'd3, 1'b0}, {2'd0, 6'd4, 1'b0}, {2'd0, 6'd5, 1'b0},
    {2'd0, 6'd6, 1'b1}, {2'd1, 6'd5, 1'b1}, {2'd1, 6'd4, 1'b1}, {2'd1, 6'd3, 1'b1},
    {2'd1, 6'd2, 1'b0}, {2'd1, 6'd1, 1'b0}, {2'd1, 6'd0, 1'b0}, {2'd2, 6'd0, 1'b0}
  };

  function automatic logic [31:0] mk_cfg(input int hi, input int lo, input bit ctl, input int rdy);
    return {2'b00, 6'(lo), 2'b00, 6'(hi), 8'h00, ctl, 1'b0, 2'(rdy), 4'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one operation per step: 0 push, 1 narrow read, 2 wide read, 3 idle
  task automatic op(input int kind, input logic [7:0] b);
    int n;
    bit rd_good;
    n = (kind == 2) ? 4 : 1;
    rd_good = 0;
    @(negedge clk);
    push_vld  = (kind == 0);
    push_byte = b;
    pop_req   = (kind == 1 || kind == 2);
    pop_wide  = (kind == 2);
    if (fifo_en && kind == 0 && mdl.size() < 32) mdl.push_back(b);
    if (fifo_en && (kind == 1 || kind == 2) && n <= mdl.size()) begin
      exp_rd = '0;
      for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mdl.pop_front();
      rd_good = 1;
    end
    @(negedge clk);
    push_vld = 1'b0;
    pop_req  = 1'b0;
    pop_wide = 1'b0;
    if (rd_good) check((n == 4) ? "R5 wide read data" : "R4 narrow read data", rd_data, exp_rd);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mdl.delete();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    cfg = mk_cfg(6, 2, 1'b1, 2);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset level", 32'(level), 0);
    check("R1 reset rts", 32'(rts), 0);
    check("R1 reset empty", 32'(ev_empty), 1);
    check("R1 reset sticky flags", {30'd0, ev_overrun, ev_ptr_err}, 0);
    check("R1 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 level, R8/R9 rts hysteresis, R7 ready (mode 2), R11 threshold flags
    for (int i = 0; i < 20; i++) begin
      e = VEC[i];
      op(int'(e[8:7]), 8'(8'h10 + i));
      check("R2 level", 32'(level), 32'(e[6:1]));
      check("R8 R9 rts hysteresis", 32'(rts), 32'(e[0]));
      check("R7 ready four-byte mode", 32'(rx_ready), 32'(e[6:1] >= 6'd4));
      check("R11 upper flag", 32'(ev_thr_hi), 32'(e[6:1] >= 6'd6));
      check("R11 lower flag", 32'(ev_thr_lo), 32'(e[6:1] <= 6'd2));
    end
    // last entry read four from empty
    check("R6 pointer error sticky", 32'(ev_ptr_err), 1);
    check("R6 rd_data kept", rd_data, exp_rd);

    // R6 oversize read with three stored
    op(0, 8'hA1); op(0, 8'hA2); op(0, 8'hA3);
    op(2, 8'h00);
    check("R6 level unchanged", 32'(level), 3);
    op(1, 8'h00);
    check("R6 nothing removed level", 32'(level), 2);

    // R1 clear
    pulse_clr();
    check("R1 clear level", 32'(level), 0);
    check("R1 clear flags", {30'd0, ev_overrun, ev_ptr_err}, 0);
    check("R1 clear empty", 32'(ev_empty), 1);

    // R7 ready modes
    cfg = mk_cfg(6, 2, 1'b1, 0);
    op(0, 8'h31);
    check("R7 mode 0 at level 1", 32'(rx_ready), 1);
    cfg = mk_cfg(6, 2, 1'b1, 1);
    op(3, 8'h00);
    check("R7 mode 1 at level 1", 32'(rx_ready), 0);
    op(0, 8'h32);
    check("R7 mode 1 at level 2", 32'(rx_ready), 1);
    cfg = mk_cfg(6, 2, 1'b1, 3);
    op(3, 8'h00);
    check("R7 mode 3 at level 2", 32'(rx_ready), 0);

    // R10 control gating
    cfg = mk_cfg(6, 2, 1'b0, 2);
    for (int i = 0; i < 4; i++) op(0, 8'(8'h40 + i));
    check("R10 level 6 with control off", 32'(level), 6);
    check("R10 rts low with control off", 32'(rts), 0);
    cfg = mk_cfg(6, 2, 1'b1, 2);
    op(3, 8'h00);
    check("R8 rts rises once control on", 32'(rts), 1);
    hs_mode = 1'b0;
    op(3, 8'h00);
    check("R10 rts low without handshake mode", 32'(rts), 0);
    hs_mode = 1'b1;
    op(3, 8'h00);
    check("R8 rts back with handshake mode", 32'(rts), 1);

    // R12 disabled queue ignores strobes
    fifo_en = 1'b0;
    op(0, 8'h77);
    check("R12 push ignored", 32'(level), 6);
    op(2, 8'h00);
    check("R12 read ignored level", 32'(level), 6);
    check("R12 no flag", {30'd0, ev_overrun, ev_ptr_err}, 0);
    check("R10 rts low when disabled", 32'(rts), 0);
    fifo_en = 1'b1;
    op(1, 8'h00);
    check("R12 queue intact after disable", 32'(level), 5);

    // R1 clear has priority over a push
    @(negedge clk);
    clr = 1'b1;
    push_vld = 1'b1;
    push_byte = 8'h99;
    @(negedge clk);
    clr = 1'b0;
    push_vld = 1'b0;
    mdl.delete();
    check("R1 clear beats push", 32'(level), 0);
    check("R1 rts after clear", 32'(rts), 0);

    // R3 fill, overflow, drain
    for (int i = 0; i < 32; i++) op(0, 8'(8'h80 + i));
    check("R2 full flag", 32'(ev_full), 1);
    check("R2 full level", 32'(level), 32);
    op(0, 8'hEE);
    check("R3 level after dropped push", 32'(level), 32);
    check("R3 overrun flag", 32'(ev_overrun), 1);
    for (int i = 0; i < 8; i++) op(2, 8'h00);
    check("R3 drained level", 32'(level), 0);
    check("R2 empty after drain", 32'(ev_empty), 1);
    check("R9 rts low after drain", 32'(rts), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule